// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the slave-side front end of an I2C controller. It watches the SCL and SDA lines through two-flop synchronizers and finds START, repeated START and STOP. It then collects the address that follows a START and compares it with a programmable own address, which can be 7 bits or 10 bits wide. When the address matches, the block pulls SDA low for the acknowledge clock. It also raises a one-cycle "addressed" pulse that carries the transfer direction.

In 10-bit mode the address spans two bytes. The block acknowledges each byte only when that byte matches. It also remembers a completed 10-bit write addressing. A master can then issue a repeated START and send only the header byte with the read bit set, and the block accepts it. After addressing, data bytes are shifted in and reported. When stretching is enabled, the block holds SCL low after every acknowledged byte until software pulses a release input. The control inputs are plain ports.

Top module: `i2c_addr_match`

## Requirements
- R1: While `enable` is low, no START or STOP is recognised. A full matching address sent in that state draws no acknowledge and no `addressed_irq`.
- R2: In 7-bit mode, if the first byte after a START has bits 7:1 equal to `own_addr[6:0]`, the block drives `sda_drive_low` high through the 9th SCL clock. It also pulses `addressed_irq` for one cycle, with `irq_rw` equal to bit 0 of that byte (1 = read).
- R3: A first byte that does not match draws no acknowledge and no interrupt. Later bytes draw none either, until the next START.
- R4: In 10-bit mode, a header byte `11110 a9 a8 0` (where a9:a8 = `own_addr[9:8]`) is acknowledged without an interrupt. A following byte equal to `own_addr[7:0]` is acknowledged and gives `addressed_irq` with `irq_rw` = 0.
- R5: In 10-bit mode, a second byte that does not equal `own_addr[7:0]` is not acknowledged and gives no interrupt.
- R6: After a completed 10-bit write addressing, a repeated START followed by the header byte with bit 0 = 1 is acknowledged and gives `addressed_irq` with `irq_rw` = 1.
- R7: The remembered 10-bit addressing is cleared by a STOP, and also by a START whose first address byte does not match. After either event, a header byte with the read bit set is not acknowledged.
- R8: With `stretch_en` high, `scl_drive_low` rises after the falling SCL edge that ends an acknowledged byte. It stays high until a `release_i` pulse and drops on the clock edge that samples the pulse.
- R9: In the write direction, each data byte is acknowledged. The byte is presented MSB first on `rx_byte`, with a one-cycle `byte_valid` pulse.
- R10: In 10-bit mode, a header byte with bit 0 = 1 and no prior write addressing, or a header whose bits 2:1 differ from `own_addr[9:8]`, is not acknowledged.
- R11: After reset, `sda_drive_low`, `scl_drive_low`, `addressed_irq` and `byte_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Enables bus condition detection and matching |
| ten_bit_mode | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| own_addr | input | 10 | Own slave address (bits 6:0 used in 7-bit mode) |
| stretch_en | input | 1 | Hold SCL low after each acknowledged byte |
| release_i | input | 1 | One-cycle pulse that releases a held SCL |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (open-drain enable) |
| sda_drive_low | output | 1 | Pull SDA low (open-drain enable) |
| addressed_irq | output | 1 | One-cycle pulse when addressed |
| irq_rw | output | 1 | Direction of the last addressing, 1 = read |
| byte_valid | output | 1 | One-cycle pulse when a data byte is complete |
| rx_byte | output | 8 | Last completed data byte |

## Verification
Every result appears on the third clock edge after the line change that causes it. There are two synchronizer stages, and the output stage is a register. An acknowledge and an addressed pulse appear three edges after the falling SCL edge that ends bit 8. A stretch appears three edges after the falling edge that ends the acknowledge clock. A release takes effect on the edge that samples the pulse. The bench holds each SCL quarter period for six clocks and samples on falling clock edges, so each check lands after its result has settled. Interrupt and data-byte events are matched, in order, against a queue of expected events filled by the driver.

// File: rtl/i2c_am_pkg.sv
`timescale 1ns/1ps
package i2c_am_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam int ADDR_W = 10;
    localparam logic [4:0] HDR10 = 5'b11110;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADR1,
        ST_ADR2,
        ST_DATA
    } am_state_e;

    typedef struct packed {
        logic      ack;
        logic      irq;
        logic      rw;
        logic      dat;
        logic      mem_set;
        logic      mem_clr;
        am_state_e nxt;
    } am_decision_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } am_bus_ev_t;

    function automatic logic hdr10_hit(input logic [BYTE_W-1:0] b, input logic [1:0] hi);
        return (b[7:3] == HDR10) && (b[2:1] == hi);
    endfunction
endpackage

// File: rtl/i2c_am_sync.sv
`timescale 1ns/1ps
module i2c_am_sync
    import i2c_am_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output am_bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0]             raw;
    logic [LINES-1:0][STAGES-1:0] chain;
    logic [LINES-1:0]             cur;
    logic [LINES-1:0]             prev;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= '1;
            else     chain[g] <= {chain[g][STAGES-2:0], raw[g]};
        end
        assign cur[g] = chain[g][STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= cur;
    end

    always_comb begin
        ev.rise  = cur[0] & ~prev[0];
        ev.fall  = ~cur[0] & prev[0];
        ev.start = cur[0] & prev[0] & prev[1] & ~cur[1];
        ev.stop  = cur[0] & prev[0] & ~prev[1] & cur[1];
        ev.sda   = cur[1];
    end
endmodule

// File: rtl/i2c_am_shift.sv
`timescale 1ns/1ps
module i2c_am_shift
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              rise,
    input  logic              fall,
    input  logic              sda,
    output logic [BYTE_W-1:0] shreg,
    output logic              ack_begin,
    output logic              ack_end
);
    localparam logic [CNT_W-1:0] SLOT_ACK = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(BYTE_W + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (rise) begin
            if (cnt < SLOT_ACK) begin
                shreg <= {shreg[BYTE_W-2:0], sda};
                cnt   <= cnt + 1'b1;
            end else if (cnt == SLOT_ACK) begin
                cnt <= SLOT_END;
            end
        end else if (fall && cnt == SLOT_END) begin
            cnt <= '0;
        end
    end

    assign ack_begin = fall && (cnt == SLOT_ACK);
    assign ack_end   = fall && (cnt == SLOT_END);

    a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= SLOT_END);
endmodule

// File: rtl/i2c_am_match.sv
`timescale 1ns/1ps
module i2c_am_match
    import i2c_am_pkg::*;
(
    input  am_state_e         st,
    input  logic              ten_bit,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] rx,
    input  logic              mem10,
    input  logic              rw_q,
    output am_decision_t      dec
);
    always_comb begin
        dec = '{ack: 1'b0, irq: 1'b0, rw: 1'b0, dat: 1'b0,
                mem_set: 1'b0, mem_clr: 1'b0, nxt: ST_IDLE};
        unique case (st)
            ST_ADR1: begin
                if (!ten_bit) begin
                    if (rx[7:1] == own_addr[6:0]) begin
                        dec.ack = 1'b1;
                        dec.irq = 1'b1;
                        dec.rw  = rx[0];
                        dec.nxt = ST_DATA;
                    end else begin
                        dec.mem_clr = 1'b1;
                    end
                end else if (hdr10_hit(rx, own_addr[9:8]) && !rx[0]) begin
                    dec.ack = 1'b1;
                    dec.nxt = ST_ADR2;
                end else if (hdr10_hit(rx, own_addr[9:8]) && mem10) begin
                    dec.ack = 1'b1;
                    dec.irq = 1'b1;
                    dec.rw  = 1'b1;
                    dec.nxt = ST_DATA;
                end else begin
                    dec.mem_clr = 1'b1;
                end
            end
            ST_ADR2: begin
                if (rx == own_addr[7:0]) begin
                    dec.ack     = 1'b1;
                    dec.irq     = 1'b1;
                    dec.mem_set = 1'b1;
                    dec.nxt     = ST_DATA;
                end else begin
                    dec.mem_clr = 1'b1;
                end
            end
            ST_DATA: begin
                dec.ack = !rw_q;
                dec.dat = 1'b1;
                dec.nxt = ST_DATA;
            end
            default: dec.nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/i2c_addr_match.sv
`timescale 1ns/1ps
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              ten_bit_mode,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_en,
    input  logic              release_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              addressed_irq,
    output logic              irq_rw,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] rx_byte
);
    am_bus_ev_t        ev;
    am_decision_t      dec;
    am_state_e         st, nxt_q;
    logic [BYTE_W-1:0] shreg;
    logic              ack_begin, ack_end;
    logic              start_g, stop_g;
    logic              pend, acked, mem10, rw_q;

    i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i), .ev(ev)
    );

    assign start_g = enable & ev.start;
    assign stop_g  = enable & ev.stop;

    i2c_am_shift u_shift (
        .clk(clk), .rst(rst), .clr(start_g), .rise(ev.rise), .fall(ev.fall),
        .sda(ev.sda), .shreg(shreg), .ack_begin(ack_begin), .ack_end(ack_end)
    );

    i2c_am_match u_match (
        .st(st), .ten_bit(ten_bit_mode), .own_addr(own_addr), .rx(shreg),
        .mem10(mem10), .rw_q(rw_q), .dec(dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= ST_IDLE;
            nxt_q         <= ST_IDLE;
            pend          <= 1'b0;
            acked         <= 1'b0;
            mem10         <= 1'b0;
            rw_q          <= 1'b0;
            sda_drive_low <= 1'b0;
            scl_drive_low <= 1'b0;
            addressed_irq <= 1'b0;
            irq_rw        <= 1'b0;
            byte_valid    <= 1'b0;
            rx_byte       <= '0;
        end else begin
            addressed_irq <= 1'b0;
            byte_valid    <= 1'b0;
            if (release_i) scl_drive_low <= 1'b0;

            if (!enable || stop_g) begin
                st            <= ST_IDLE;
                pend          <= 1'b0;
                mem10         <= 1'b0;
                sda_drive_low <= 1'b0;
            end else if (start_g) begin
                st            <= ST_ADR1;
                pend          <= 1'b0;
                sda_drive_low <= 1'b0;
            end else if (ack_begin && st != ST_IDLE) begin
                pend          <= 1'b1;
                acked         <= dec.ack;
                nxt_q         <= dec.nxt;
                sda_drive_low <= dec.ack;
                addressed_irq <= dec.irq;
                if (dec.irq) begin
                    rw_q   <= dec.rw;
                    irq_rw <= dec.rw;
                end
                if (dec.mem_set) mem10 <= 1'b1;
                if (dec.mem_clr) mem10 <= 1'b0;
                if (dec.dat) begin
                    byte_valid <= 1'b1;
                    rx_byte    <= shreg;
                end
            end else if (ack_end && pend) begin
                pend          <= 1'b0;
                sda_drive_low <= 1'b0;
                st            <= nxt_q;
                if (acked && stretch_en) scl_drive_low <= 1'b1;
            end
        end
    end

    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!sda_drive_low && !addressed_irq));
    a_r2_irq_with_ack: assert property (@(posedge clk) disable iff (rst)
        addressed_irq |-> sda_drive_low);
    a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_drive_low);
    a_r6_mem_from_write: assert property (@(posedge clk) disable iff (rst)
        $rose(mem10) |-> (addressed_irq && !irq_rw));
    a_r7_stop_clears_mem: assert property (@(posedge clk) disable iff (rst)
        stop_g |=> !mem10);
    a_r8_stretch_holds: assert property (@(posedge clk) disable iff (rst)
        (scl_drive_low && !release_i) |=> scl_drive_low);
    a_r8_stretch_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_drive_low) |-> $past(ack_end));
endmodule

// File: tb/i2c_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_addr_match_tb;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0, ten_bit_mode = 1'b0, stretch_en = 1'b0, release_i = 1'b0;
    logic [9:0] own_addr = 10'h2B5;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_line, sda_line;
    logic scl_drive_low, sda_drive_low, addressed_irq, irq_rw, byte_valid;
    logic [7:0] rx_byte;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    assign scl_line = scl_m & ~scl_drive_low;
    assign sda_line = sda_m & ~sda_drive_low;

    i2c_addr_match u_dut (
        .clk(clk), .rst(rst), .enable(enable), .ten_bit_mode(ten_bit_mode),
        .own_addr(own_addr), .stretch_en(stretch_en), .release_i(release_i),
        .scl_i(scl_line), .sda_i(sda_line), .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low), .addressed_irq(addressed_irq),
        .irq_rw(irq_rw), .byte_valid(byte_valid), .rx_byte(rx_byte)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic push(input bit is_data, input logic [7:0] v, input string tag);
        exp_q.push_back({is_data, v});
        tag_q.push_back(tag);
    endtask

    // Scoreboard monitor: every event the design produces is compared with the queue.
    always @(negedge clk) begin
        if (!rst && (addressed_irq || byte_valid)) begin
            logic [8:0] got;
            got = addressed_irq ? {1'b0, 7'd0, irq_rw} : {1'b1, rx_byte};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected event", int'(got), 0);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(got == e, t, int'(got), int'(e));
            end
        end
    end

    task automatic do_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wait_high(); wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wait_high(); wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic xfer(input logic [7:0] b, input bit exp_ack, input string tag);
        logic ackd;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wait_high(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wait_high(); wq();
        ackd = sda_drive_low;
        scl_m = 1'b0; wq();
        chk(ackd == exp_ack, tag, int'(ackd), int'(exp_ack));
    endtask

    task automatic release_stretch(input string tag);
        chk(scl_drive_low == 1'b1, tag, int'(scl_drive_low), 1);
        repeat (20) @(negedge clk);
        chk(scl_drive_low == 1'b1, tag, int'(scl_drive_low), 1);
        release_i = 1'b1; @(negedge clk); release_i = 1'b0;
        chk(scl_drive_low == 1'b0, tag, int'(scl_drive_low), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!sda_drive_low && !scl_drive_low && !addressed_irq && !byte_valid,
            "R11 reset outputs", {sda_drive_low, scl_drive_low, addressed_irq, byte_valid}, 0);

        // R1 disabled: matching 7-bit address ignored
        do_start(); xfer(8'h6A, 1'b0, "R1 disabled no ack"); do_stop();
        enable = 1'b1; wq();

        // R2 / R9 7-bit write with data
        do_start();
        push(1'b0, 8'h00, "R2 irq write");
        xfer(8'h6A, 1'b1, "R2 ack 7-bit");
        push(1'b1, 8'hC3, "R9 data C3");
        xfer(8'hC3, 1'b1, "R9 ack data");
        push(1'b1, 8'h5A, "R9 data 5A");
        xfer(8'h5A, 1'b1, "R9 ack data");
        do_stop();

        // R2 7-bit read
        do_start();
        push(1'b0, 8'h01, "R2 irq read");
        xfer(8'h6B, 1'b1, "R2 ack read");
        do_stop();

        // R3 mismatch, following byte ignored
        do_start();
        xfer(8'h6C, 1'b0, "R3 mismatch nack");
        xfer(8'h6A, 1'b0, "R3 ignored until start");
        do_stop();

        // R8 stretch
        stretch_en = 1'b1;
        do_start();
        push(1'b0, 8'h00, "R8 irq");
        xfer(8'h6A, 1'b1, "R8 ack");
        release_stretch("R8 stretch addr");
        push(1'b1, 8'h81, "R8 data");
        xfer(8'h81, 1'b1, "R8 ack data");
        release_stretch("R8 stretch data");
        do_stop();
        stretch_en = 1'b0;

        // R4 / R6 10-bit write then repeated start read
        ten_bit_mode = 1'b1;
        do_start();
        xfer(8'hF4, 1'b1, "R4 header ack");
        push(1'b0, 8'h00, "R4 irq write");
        xfer(8'hB5, 1'b1, "R4 low byte ack");
        push(1'b1, 8'h3C, "R9 10-bit data");
        xfer(8'h3C, 1'b1, "R9 ack data");
        do_start();
        push(1'b0, 8'h01, "R6 irq read");
        xfer(8'hF5, 1'b1, "R6 header read ack");
        do_stop();

        // R7 STOP clears memory
        do_start();
        xfer(8'hF5, 1'b0, "R7 read after stop nack");
        do_stop();

        // R10 wrong upper bits
        do_start();
        xfer(8'hF0, 1'b0, "R10 header mismatch nack");
        do_stop();

        // R5 second byte mismatch, no memory set
        do_start();
        xfer(8'hF4, 1'b1, "R5 header ack");
        xfer(8'hB4, 1'b0, "R5 low mismatch nack");
        do_start();
        xfer(8'hF5, 1'b0, "R10 read without memory nack");
        do_stop();

        // R7 mismatching START clears memory
        do_start();
        xfer(8'hF4, 1'b1, "R7 header ack");
        push(1'b0, 8'h00, "R7 irq write");
        xfer(8'hB5, 1'b1, "R7 low ack");
        do_start();
        xfer(8'h6A, 1'b0, "R7 mismatch start nack");
        do_start();
        xfer(8'hF5, 1'b0, "R7 memory cleared nack");
        do_stop();

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R2 missing events", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule